// File: doc/BRIEF.md
# Dual-Butterfly 16-Point FFT Core

This block computes a 16-point complex forward FFT on fixed-point samples. It uses the radix-2 decimation-in-frequency algorithm and works in place. A frame of sixteen complex samples enters the core one per handshake. The core stores the frame in a register-based working memory. Once it receives a start command, it runs four butterfly stages. Each stage takes four clock cycles, because two butterflies are evaluated together in every cycle. The core then presents the sixteen bins in natural order on an output handshake. Bit-reversed addressing on the read side does the unscrambling.

Both butterflies get their coefficients from one twiddle generator. The generator reads a four-entry table. The second lane's coefficient is the first lane's coefficient rotated by -j, which needs only a swap of the real and imaginary parts and one negation. The schedule always pairs two butterflies whose twiddle exponents differ by four, so this rotation gives the exact coefficient the second lane needs. The one exception is the last stage, where every coefficient is unity and both lanes share it unchanged.

Each butterfly halves its outputs, so the results equal the DFT scaled by 1/16. A typical user streams a frame in, pulses start, waits for the done pulse, and drains the bins. The input side stays closed from the moment the frame is complete until the last bin has been taken.

Top module: `fft2bf_core`

## Requirements
- R1: While reset is applied and in the first cycle after it, `in_ready` is 1, `out_valid` is 0 and `done` is 0.
- R2: The core takes exactly 16 samples, one on each cycle where `in_valid` and `in_ready` are both 1. `in_ready` drops after the 16th sample and stays 0 until the cycle after the 16th output handshake, when it returns to 1. `in_ready` and `out_valid` are never 1 together.
- R3: `start` has no effect while a frame is only partly loaded. After the 16th sample, the core waits, with `out_valid` at 0, until it samples `start` high.
- R4: Output number k (k = 0..15, in handshake order) carries bin k of X[k] = (1/16)·Σ x[n]·e^(-j2πkn/16) as 16-bit signed real and imaginary parts, each within 4 LSB of the exact value.
- R5: Every butterfly halves its sum and difference paths. Twiddles are Q1.14, so unity is 16384. An impulse (A, B) at input index 0, with A and B multiples of 16, therefore produces exactly (A/16, B/16) in every bin.
- R6: `done` is high for exactly one cycle, in the same cycle that `out_valid` first goes high for a frame.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_re` and `out_im` keep their values in the next cycle.
- R8: `out_valid` first rises after the 16th rising clock edge that follows the edge at which `start` is accepted. That is four stages of four butterfly-pair steps.
- R9: After its last output, the core accepts a new frame at once, and that frame is transformed independently of the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Core accepts a sample this cycle |
| in_re | input | DATA_W | Input sample, real part |
| in_im | input | DATA_W | Input sample, imaginary part |
| start | input | 1 | Begin the transform of a fully loaded frame |
| out_valid | output | 1 | Output bin present |
| out_ready | input | 1 | Consumer takes the bin this cycle |
| out_re | output | DATA_W | Output bin, real part |
| out_im | output | DATA_W | Output bin, imaginary part |
| done | output | 1 | One-cycle pulse with the first valid bin |

## Verification
The embedded properties check the handshake behaviour on every cycle. They cover the exclusive input and output windows, the drop of `in_ready` right after an accepted sample, output stability under back-pressure, the alignment of `done` with the first valid bin, and that the four addresses touched in each butterfly step never collide. The numeric result can only be shown by the bench scenarios. These compare each bin against a DFT computed in real arithmetic for impulses, a DC frame, complex and real tones, and a pseudo-random frame. The bench scenarios also cover the exactness of the impulse case, the 16-edge latency, and the refusal of `start` on a partial frame.

// File: rtl/fft2bf_pkg.sv
package fft2bf_pkg;

   localparam int LOG2N   = 4;
   localparam int NPTS    = 1 << LOG2N;
   localparam int EXP_W   = LOG2N - 2;
   localparam int STEP_W  = LOG2N - 2;
   localparam int STAGE_W = $clog2(LOG2N);

   typedef enum logic [1:0] {
      ST_LOAD,
      ST_FULL,
      ST_RUN,
      ST_DRAIN
   } fft_state_e;

   function automatic logic [LOG2N-1:0] bit_rev(input logic [LOG2N-1:0] v);
      logic [LOG2N-1:0] r;
      for (int i = 0; i < LOG2N; i++) r[i] = v[LOG2N-1-i];
      return r;
   endfunction

   // first-quadrant cosine of 2*pi*e/16, Q1.14
   function automatic logic signed [15:0] cos_q14(input logic [EXP_W-1:0] e);
      case (e)
         2'd0:    return 16'sd16384;
         2'd1:    return 16'sd15137;
         2'd2:    return 16'sd11585;
         default: return 16'sd6270;
      endcase
   endfunction

   function automatic logic signed [15:0] sin_q14(input logic [EXP_W-1:0] e);
      case (e)
         2'd0:    return 16'sd0;
         2'd1:    return 16'sd6270;
         2'd2:    return 16'sd11585;
         default: return 16'sd15137;
      endcase
   endfunction

endpackage

// File: rtl/fft2bf_agen.sv
module fft2bf_agen
   import fft2bf_pkg::*;
(
   input  logic [STAGE_W-1:0] stage,
   input  logic [STEP_W-1:0]  step,
   output logic [LOG2N-1:0]   top0,
   output logic [LOG2N-1:0]   bot0,
   output logic [LOG2N-1:0]   top1,
   output logic [LOG2N-1:0]   bot1,
   output logic [EXP_W-1:0]   tw_exp,
   output logic               tw_rot
);

   localparam int LAST_STAGE = LOG2N - 1;

   int q_i;
   int lo_i;
   int base_i;
   int span_i;
   int half_i;

   always_comb begin
      q_i    = 0;
      lo_i   = 0;
      base_i = int'(step) * 4;
      span_i = 1;
      half_i = 2;
      tw_rot = 1'b0;
      if (int'(stage) != LAST_STAGE) begin
         // zero bits inserted at q and q+1; lanes differ by a quarter period
         q_i    = LOG2N - 2 - int'(stage);
         lo_i   = int'(step) & ((1 << q_i) - 1);
         base_i = ((int'(step) >> q_i) << (q_i + 2)) | lo_i;
         span_i = 1 << (q_i + 1);
         half_i = 1 << q_i;
         tw_rot = 1'b1;
      end
      top0   = LOG2N'(base_i);
      bot0   = LOG2N'(base_i + span_i);
      top1   = LOG2N'(base_i + half_i);
      bot1   = LOG2N'(base_i + half_i + span_i);
      tw_exp = EXP_W'(lo_i << int'(stage));
   end

endmodule

// File: rtl/fft2bf_twiddle.sv
module fft2bf_twiddle
   import fft2bf_pkg::*;
#(
   parameter int TW_W = 16
) (
   input  logic [EXP_W-1:0]       tw_exp,
   input  logic                   tw_rot,
   output logic signed [TW_W-1:0] w0_re,
   output logic signed [TW_W-1:0] w0_im,
   output logic signed [TW_W-1:0] w1_re,
   output logic signed [TW_W-1:0] w1_im
);

   localparam int DROP = 16 - TW_W;

   logic signed [15:0] c_full;
   logic signed [15:0] s_full;

   always_comb begin
      c_full = cos_q14(tw_exp) >>> DROP;
      s_full = sin_q14(tw_exp) >>> DROP;
      w0_re  = TW_W'(c_full);
      w0_im  = -TW_W'(s_full);
      if (tw_rot) begin
         // times -j: (re, im) -> (im, -re)
         w1_re = w0_im;
         w1_im = -w0_re;
      end else begin
         w1_re = w0_re;
         w1_im = w0_im;
      end
   end

endmodule

// File: rtl/fft2bf_butterfly.sv
module fft2bf_butterfly #(
   parameter int DATA_W = 16,
   parameter int TW_W   = 16
) (
   input  logic signed [DATA_W-1:0] a_re,
   input  logic signed [DATA_W-1:0] a_im,
   input  logic signed [DATA_W-1:0] b_re,
   input  logic signed [DATA_W-1:0] b_im,
   input  logic signed [TW_W-1:0]   w_re,
   input  logic signed [TW_W-1:0]   w_im,
   output logic signed [DATA_W-1:0] s_re,
   output logic signed [DATA_W-1:0] s_im,
   output logic signed [DATA_W-1:0] d_re,
   output logic signed [DATA_W-1:0] d_im
);

   localparam int EW = DATA_W + 1;
   localparam int PW = DATA_W + TW_W + 2;
   localparam int SH = TW_W - 1;
   localparam logic signed [PW-1:0] HI = $signed({{(PW-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}});
   localparam logic signed [PW-1:0] LO = -HI - 1;

   function automatic logic signed [DATA_W-1:0] clip(input logic signed [PW-1:0] v);
      if (v > HI) return DATA_W'(HI);
      if (v < LO) return DATA_W'(LO);
      return DATA_W'(v);
   endfunction

   logic signed [EW-1:0] sum_re, sum_im, dif_re, dif_im;
   logic signed [PW-1:0] prd_re, prd_im;

   always_comb begin
      sum_re = EW'(a_re) + EW'(b_re);
      sum_im = EW'(a_im) + EW'(b_im);
      dif_re = EW'(a_re) - EW'(b_re);
      dif_im = EW'(a_im) - EW'(b_im);
      prd_re = PW'(dif_re) * PW'(w_re) - PW'(dif_im) * PW'(w_im);
      prd_im = PW'(dif_re) * PW'(w_im) + PW'(dif_im) * PW'(w_re);
      s_re   = sum_re[EW-1:1];
      s_im   = sum_im[EW-1:1];
      d_re   = clip(prd_re >>> SH);
      d_im   = clip(prd_im >>> SH);
   end

endmodule

// File: rtl/fft2bf_core.sv
module fft2bf_core
   import fft2bf_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int TW_W   = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [DATA_W-1:0] in_re,
   input  logic [DATA_W-1:0] in_im,
   input  logic              start,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [DATA_W-1:0] out_re,
   output logic [DATA_W-1:0] out_im,
   output logic              done
);

   localparam int LANES = 2;

   if (DATA_W < 8 || DATA_W > 24) begin : g_dw_chk
      $error("fft2bf_core: DATA_W must be in 8..24");
   end
   if (TW_W < 8 || TW_W > 16) begin : g_tw_chk
      $error("fft2bf_core: TW_W must be in 8..16");
   end

   fft_state_e          state;
   logic [LOG2N-1:0]    load_idx;
   logic [LOG2N-1:0]    out_idx;
   logic [STAGE_W-1:0]  stage;
   logic [STEP_W-1:0]   step;
   logic                done_q;

   logic signed [DATA_W-1:0] mem_re [NPTS];
   logic signed [DATA_W-1:0] mem_im [NPTS];

   logic [LOG2N-1:0]          top_a [LANES];
   logic [LOG2N-1:0]          bot_a [LANES];
   logic signed [TW_W-1:0]    tw_re [LANES];
   logic signed [TW_W-1:0]    tw_im [LANES];
   logic signed [DATA_W-1:0]  s_re  [LANES];
   logic signed [DATA_W-1:0]  s_im  [LANES];
   logic signed [DATA_W-1:0]  d_re  [LANES];
   logic signed [DATA_W-1:0]  d_im  [LANES];
   logic [EXP_W-1:0]          tw_exp;
   logic                      tw_rot;

   fft2bf_agen u_agen (
      .stage  (stage),
      .step   (step),
      .top0   (top_a[0]),
      .bot0   (bot_a[0]),
      .top1   (top_a[1]),
      .bot1   (bot_a[1]),
      .tw_exp (tw_exp),
      .tw_rot (tw_rot)
   );

   fft2bf_twiddle #(.TW_W(TW_W)) u_twid (
      .tw_exp (tw_exp),
      .tw_rot (tw_rot),
      .w0_re  (tw_re[0]),
      .w0_im  (tw_im[0]),
      .w1_re  (tw_re[1]),
      .w1_im  (tw_im[1])
   );

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      fft2bf_butterfly #(.DATA_W(DATA_W), .TW_W(TW_W)) u_bf (
         .a_re (mem_re[top_a[g]]),
         .a_im (mem_im[top_a[g]]),
         .b_re (mem_re[bot_a[g]]),
         .b_im (mem_im[bot_a[g]]),
         .w_re (tw_re[g]),
         .w_im (tw_im[g]),
         .s_re (s_re[g]),
         .s_im (s_im[g]),
         .d_re (d_re[g]),
         .d_im (d_im[g])
      );
   end

   // sequencer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_LOAD;
         load_idx <= '0;
         out_idx  <= '0;
         stage    <= '0;
         step     <= '0;
         done_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state)
            ST_LOAD: if (in_valid) begin
               load_idx <= load_idx + 1'b1;
               if (&load_idx) state <= ST_FULL;
            end
            ST_FULL: if (start) begin
               state <= ST_RUN;
               stage <= '0;
               step  <= '0;
            end
            ST_RUN: begin
               step <= step + 1'b1;
               if (&step) begin
                  stage <= stage + 1'b1;
                  if (int'(stage) == LOG2N - 1) begin
                     state   <= ST_DRAIN;
                     out_idx <= '0;
                     done_q  <= 1'b1;
                  end
               end
            end
            default: if (out_ready) begin
               out_idx <= out_idx + 1'b1;
               if (&out_idx) state <= ST_LOAD;
            end
         endcase
      end
   end

   // working memory: one write port while loading, four during a step
   always_ff @(posedge clk) begin
      if (state == ST_LOAD && in_valid) begin
         mem_re[load_idx] <= in_re;
         mem_im[load_idx] <= in_im;
      end else if (state == ST_RUN) begin
         for (int g = 0; g < LANES; g++) begin
            mem_re[top_a[g]] <= s_re[g];
            mem_im[top_a[g]] <= s_im[g];
            mem_re[bot_a[g]] <= d_re[g];
            mem_im[bot_a[g]] <= d_im[g];
         end
      end
   end

   assign in_ready  = (state == ST_LOAD);
   assign out_valid = (state == ST_DRAIN);
   assign out_re    = mem_re[bit_rev(out_idx)];
   assign out_im    = mem_im[bit_rev(out_idx)];
   assign done      = done_q;

   // R2
   in_out_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_ready && out_valid));

   // R2
   in_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(in_ready) |-> $past(in_valid));

   // R2
   in_reopen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(out_valid) |-> $past(out_ready) && in_ready);

   // R6
   done_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $rose(out_valid));

   // R7
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_re) && $stable(out_im));

   // R4
   addr_disjoint_chk: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_RUN |-> top_a[0] != bot_a[0] && top_a[0] != top_a[1] &&
                          top_a[0] != bot_a[1] && bot_a[0] != top_a[1] &&
                          bot_a[0] != bot_a[1] && top_a[1] != bot_a[1]);

endmodule

// File: tb/test_fft2bf_core.sv
`timescale 1ns/1ps
module test_fft2bf_core;

   localparam int DW  = 16;
   localparam int TOL = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic          start = 1'b0;
   logic          out_ready = 1'b0;
   logic [DW-1:0] in_re = '0;
   logic [DW-1:0] in_im = '0;
   logic          in_ready, out_valid, done;
   logic [DW-1:0] out_re, out_im;

   fft2bf_core #(.DATA_W(DW), .TW_W(16)) i_fft2bf_core (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_re(in_re), .in_im(in_im), .start(start), .out_valid(out_valid),
      .out_ready(out_ready), .out_re(out_re), .out_im(out_im), .done(done)
   );

   always #2 clk = ~clk;

   int n_tests = 0;
   int n_fail  = 0;
   int fr_re [16];
   int fr_im [16];
   int got_re [16];
   int got_im [16];

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int sx(input logic [DW-1:0] v);
      return int'($signed(v));
   endfunction

   task automatic load_range(input int first, input int last);
      for (int i = first; i <= last; i++) begin
         while (!in_ready) @(negedge clk);
         in_valid = 1'b1;
         in_re    = DW'(fr_re[i]);
         in_im    = DW'(fr_im[i]);
         @(negedge clk);
      end
      in_valid = 1'b0;
   endtask

   // start, measure latency, drain with back-pressure
   task automatic run_frame(input string name);
      int  edges;
      int  idx;
      int  k;
      bit  ir_bad;
      bit  dn_bad;
      bit  hold_bad;
      bit  was_stall;
      int  h_re;
      int  h_im;
      ir_bad = 0; dn_bad = 0; hold_bad = 0; was_stall = 0; h_re = 0; h_im = 0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      edges = 0;
      while (!out_valid && edges < 40) begin
         if (in_ready) ir_bad = 1;
         if (done) dn_bad = 1;
         @(negedge clk);
         edges++;
      end
      check(edges == 16, "R8", {name, " latency edges"}, edges, 16);
      check(done == 1'b1, "R6", {name, " done with first bin"}, int'(done), 1);
      idx = 0;
      k = 0;
      while (idx < 16 && k < 80) begin
         if (in_ready) ir_bad = 1;
         if (k > 0 && done) dn_bad = 1;
         if (was_stall && (sx(out_re) != h_re || sx(out_im) != h_im || !out_valid)) hold_bad = 1;
         out_ready = (k % 3 != 1);
         if (out_ready) begin
            got_re[idx] = sx(out_re);
            got_im[idx] = sx(out_im);
            idx++;
            was_stall = 0;
         end else begin
            h_re = sx(out_re);
            h_im = sx(out_im);
            was_stall = 1;
         end
         @(negedge clk);
         k++;
      end
      out_ready = 1'b0;
      check(!ir_bad, "R2", {name, " in_ready low while busy"}, int'(ir_bad), 0);
      check(!dn_bad, "R6", {name, " done only one cycle"}, int'(dn_bad), 0);
      check(!hold_bad, "R7", {name, " bin held under back-pressure"}, int'(hold_bad), 0);
      check(in_ready == 1'b1, "R9", {name, " in_ready back after last bin"}, int'(in_ready), 1);
      check(out_valid == 1'b0, "R2", {name, " out_valid low after last bin"}, int'(out_valid), 0);
   endtask

   task automatic compare_dft(input string name);
      real er, ei, a;
      int  xr, xi;
      bit  bad;
      for (int k = 0; k < 16; k++) begin
         er = 0.0; ei = 0.0;
         for (int n = 0; n < 16; n++) begin
            a  = 2.0 * 3.14159265358979 * real'(k * n) / 16.0;
            er = er + real'(fr_re[n]) * $cos(a) + real'(fr_im[n]) * $sin(a);
            ei = ei + real'(fr_im[n]) * $cos(a) - real'(fr_re[n]) * $sin(a);
         end
         xr  = int'(er / 16.0);
         xi  = int'(ei / 16.0);
         bad = (got_re[k] - xr > TOL) || (xr - got_re[k] > TOL);
         check(!bad, "R4", $sformatf("%s bin %0d re", name, k), got_re[k], xr);
         bad = (got_im[k] - xi > TOL) || (xi - got_im[k] > TOL);
         check(!bad, "R4", $sformatf("%s bin %0d im", name, k), got_im[k], xi);
      end
   endtask

   task automatic clear_frame();
      for (int n = 0; n < 16; n++) begin
         fr_re[n] = 0;
         fr_im[n] = 0;
      end
   endtask

   task automatic set_tone(input int kk, input real amp, input bit cplx);
      real a;
      for (int n = 0; n < 16; n++) begin
         a = 2.0 * 3.14159265358979 * real'(kk * n) / 16.0;
         fr_re[n] = int'(amp * $cos(a));
         fr_im[n] = cplx ? int'(amp * $sin(a)) : 0;
      end
   endtask

   task automatic full_frame(input string name);
      load_range(0, 15);
      run_frame(name);
      compare_dft(name);
   endtask

   initial begin
      #(4 * 150000);
      n_tests++;
      n_fail++;
      $display("FAIL R8 watchdog expired: actual 1 expected 0");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      int seed;
      repeat (3) @(negedge clk);
      // R1 during reset
      check(in_ready == 1'b1, "R1", "in_ready in reset", int'(in_ready), 1);
      check(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
      check(done == 1'b0, "R1", "done in reset", int'(done), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(in_ready == 1'b1 && out_valid == 1'b0 && done == 1'b0, "R1",
            "idle after reset", int'({in_ready, out_valid, done}), 4);

      // R3: start on partial frame has no effect; R5 exact impulse
      clear_frame();
      fr_re[0] = 16000;
      fr_im[0] = -8000;
      load_range(0, 4);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      begin
         bit seen = 0;
         for (int c = 0; c < 20; c++) begin
            if (out_valid || !in_ready) seen = 1;
            @(negedge clk);
         end
         check(!seen, "R3", "start ignored on partial frame", int'(seen), 0);
      end
      load_range(5, 15);
      check(in_ready == 1'b0, "R2", "in_ready low after 16 samples", int'(in_ready), 0);
      begin
         bit seen = 0;
         for (int c = 0; c < 10; c++) begin
            if (out_valid || in_ready) seen = 1;
            @(negedge clk);
         end
         check(!seen, "R3", "full frame waits for start", int'(seen), 0);
      end
      run_frame("impulse0");
      for (int k = 0; k < 16; k++) begin
         check(got_re[k] == 1000, "R5", $sformatf("impulse0 bin %0d re", k), got_re[k], 1000);
         check(got_im[k] == -500, "R5", $sformatf("impulse0 bin %0d im", k), got_im[k], -500);
      end

      // R4 shifted impulse: every twiddle exponent appears
      clear_frame();
      fr_re[5] = 12000;
      fr_im[5] = 4000;
      full_frame("impulse5");

      // R4 DC frame
      for (int n = 0; n < 16; n++) begin
         fr_re[n] = 4000;
         fr_im[n] = -2000;
      end
      full_frame("dc");

      // R4 complex tones, R9 back-to-back frames
      set_tone(1, 8000.0, 1'b1);
      full_frame("tone1");
      set_tone(5, 8000.0, 1'b1);
      full_frame("tone5");
      set_tone(11, 7000.0, 1'b1);
      full_frame("tone11");
      set_tone(2, 9000.0, 1'b0);
      full_frame("cos2");

      // R4 pseudo-random frame
      seed = 12345;
      for (int n = 0; n < 16; n++) begin
         seed = seed * 1103515245 + 12345;
         fr_re[n] = ((seed >>> 8) % 8000);
         seed = seed * 1103515245 + 12345;
         fr_im[n] = ((seed >>> 8) % 8000);
      end
      full_frame("random");

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule